// File: doc/BRIEF.md
# DMA Channel Set/Clear Control Registers

This block is the register bank that a multi-channel DMA controller uses to hold two per-channel vectors: a request mask and a channel enable. Software never writes either vector directly. Each vector has a write-one-to-set address and a write-one-to-clear address, so one channel can be changed without a read-modify-write. A write of zero to any bit leaves that bit alone.

The bank is reached over a simple register bus with an address, a write strobe with write data, and a read strobe with registered read data. It also takes one request line per channel from the peripherals. For each channel it returns a request that passes only when that channel is enabled and not masked. The request is registered for one cycle. The enable vector is driven out directly as per-channel status for the rest of the controller.

Each access is decoded into one of five register selections: `SEL_NONE`, `SEL_MASK_SET`, `SEL_MASK_CLR`, `SEL_EN_SET` and `SEL_EN_CLR`. A write with a set selection ORs the data into its vector. A write with a clear selection removes the data's ones from its vector. A read with `SEL_MASK_SET` or `SEL_EN_SET` loads that vector into the read register. Every other read loads zero. The read register returns to zero in any cycle that follows no read.

Top module: `dma_chctl_regs`

## Requirements
- R1: After reset the mask vector, the enable vector, `chan_en`, `gated_req` and `bus_rd_data` are all zero.
- R2: A write to byte offset 0x20 sets mask bit C for every data bit C (C from 0 to 13) that is 1. Data bits that are 0, and data bits 31 to 14, leave the mask unchanged.
- R3: A write to offset 0x24 clears mask bit C for every data bit C that is 1. Data bits that are 0 have no effect.
- R4: A write to offset 0x28 sets enable bit C for every data bit C that is 1. Data bits that are 0 have no effect.
- R5: A write to offset 0x2C clears enable bit C for every data bit C that is 1. Data bits that are 0 have no effect.
- R6: A read with `bus_rd_en` high presents data on `bus_rd_data` in the next cycle. Offset 0x20 returns the mask in bits 13:0, where 1 means masked. Offset 0x28 returns the enable vector in bits 13:0. Bits 31 to 14 always read 0.
- R7: Reads of offsets 0x24 and 0x2C return zero.
- R8: Writes to any other address, including unaligned addresses such as 0x21, change neither vector. Reads of those addresses return zero.
- R9: `gated_req[C]` equals `periph_req[C] & ~mask[C] & enable[C]` as sampled at the previous clock edge. This is a one-cycle registered path.
- R10: `chan_en` equals the enable vector. It shows a write in the cycle after the write's clock edge.
- R11: `bus_rd_data` is zero in every cycle that follows a cycle with `bus_rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_rd_data | output | 32 | Read data, valid in the cycle after `bus_rd_en` |
| periph_req | input | 14 | Per-channel peripheral request inputs |
| gated_req | output | 14 | Per-channel requests after mask and enable gating |
| chan_en | output | 14 | Per-channel enable status |

## Verification
On every cycle, the assertions check these rules:
- A set write leaves every written one set in its vector, and a clear write leaves none of them set.
- A vector with no strobe on it holds its value.
- A gated request never passes for a channel that was masked or disabled in the previous cycle.
- The reserved read bits stay zero, and the read data returns to zero after an idle cycle or a read of a clear address.

Only the bench scenarios can show the rest:
- The exact readback values after sequences of writes through the four aliases.
- The full value of the gated requests under different request patterns, including their one-cycle latency.
- That unmapped and unaligned addresses leave both vectors untouched.

// File: rtl/dma_chctl_pkg.sv
package dma_chctl_pkg;

    // Byte offsets of the four aliases
    localparam logic [31:0] OFS_MASK_SET = 32'h20;
    localparam logic [31:0] OFS_MASK_CLR = 32'h24;
    localparam logic [31:0] OFS_EN_SET   = 32'h28;
    localparam logic [31:0] OFS_EN_CLR   = 32'h2C;

    typedef enum logic [2:0] {
        SEL_NONE     = 3'd0,
        SEL_MASK_SET = 3'd1,
        SEL_MASK_CLR = 3'd2,
        SEL_EN_SET   = 3'd3,
        SEL_EN_CLR   = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/dma_chctl_decode.sv
module dma_chctl_decode
    import dma_chctl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr_i,
    output reg_sel_e      sel_o
);

    always_comb begin
        unique case (addr_i)
            AW'(OFS_MASK_SET): sel_o = SEL_MASK_SET;
            AW'(OFS_MASK_CLR): sel_o = SEL_MASK_CLR;
            AW'(OFS_EN_SET):   sel_o = SEL_EN_SET;
            AW'(OFS_EN_CLR):   sel_o = SEL_EN_CLR;
            default:           sel_o = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/dma_chctl_setclr.sv
module dma_chctl_setclr #(
    parameter int NCH = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_stb_i,
    input  logic           clr_stb_i,
    input  logic [NCH-1:0] bits_i,
    output logic [NCH-1:0] vec_o
);

    logic [NCH-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (set_stb_i) begin
            vec_q <= vec_q | bits_i;
        end else if (clr_stb_i) begin
            vec_q <= vec_q & ~bits_i;
        end
    end

    assign vec_o = vec_q;

    // R2 R4
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb_i |=> ((vec_q & $past(bits_i)) == $past(bits_i)));

    // R3 R5
    clr_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb_i && !set_stb_i) |=> ((vec_q & $past(bits_i)) == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb_i && !clr_stb_i) |=> $stable(vec_q));

endmodule

// File: rtl/dma_chctl_gate.sv
module dma_chctl_gate #(
    parameter int NCH = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic [NCH-1:0] mask_i,
    input  logic [NCH-1:0] en_i,
    output logic [NCH-1:0] gated_o
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gated_o[c] <= 1'b0;
            end else begin
                gated_o[c] <= req_i[c] & ~mask_i[c] & en_i[c];
            end
        end
    end

    // R9
    blocked_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gated_o & ($past(mask_i) | ~$past(en_i))) == '0));

endmodule

// File: rtl/dma_chctl_regs.sv
module dma_chctl_regs
    import dma_chctl_pkg::*;
#(
    parameter int NCH = 14,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr_en,
    input  logic [DW-1:0]  bus_wr_data,
    input  logic           bus_rd_en,
    output logic [DW-1:0]  bus_rd_data,
    input  logic [NCH-1:0] periph_req,
    output logic [NCH-1:0] gated_req,
    output logic [NCH-1:0] chan_en
);

    localparam int PADW = DW - NCH;

    reg_sel_e       sel;
    logic [NCH-1:0] wr_bits;
    logic [NCH-1:0] mask_vec;
    logic [NCH-1:0] en_vec;
    logic           mask_set_stb, mask_clr_stb, en_set_stb, en_clr_stb;
    logic [DW-1:0]  rd_q;
    logic           unused_wr_hi;

    assign wr_bits      = bus_wr_data[NCH-1:0];
    assign unused_wr_hi = ^bus_wr_data[DW-1:NCH];

    dma_chctl_decode #(.AW(AW)) u_decode (
        .addr_i (bus_addr),
        .sel_o  (sel)
    );

    always_comb begin
        mask_set_stb = 1'b0;
        mask_clr_stb = 1'b0;
        en_set_stb   = 1'b0;
        en_clr_stb   = 1'b0;
        if (bus_wr_en) begin
            unique case (sel)
                SEL_MASK_SET: mask_set_stb = 1'b1;
                SEL_MASK_CLR: mask_clr_stb = 1'b1;
                SEL_EN_SET:   en_set_stb   = 1'b1;
                SEL_EN_CLR:   en_clr_stb   = 1'b1;
                default:      ;
            endcase
        end
    end

    dma_chctl_setclr #(.NCH(NCH)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stb_i (mask_set_stb),
        .clr_stb_i (mask_clr_stb),
        .bits_i    (wr_bits),
        .vec_o     (mask_vec)
    );

    dma_chctl_setclr #(.NCH(NCH)) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stb_i (en_set_stb),
        .clr_stb_i (en_clr_stb),
        .bits_i    (wr_bits),
        .vec_o     (en_vec)
    );

    dma_chctl_gate #(.NCH(NCH)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (periph_req),
        .mask_i  (mask_vec),
        .en_i    (en_vec),
        .gated_o (gated_req)
    );

    // Registered readback; a cycle with no read loads zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (bus_rd_en) begin
            unique case (sel)
                SEL_MASK_SET: rd_q <= {{PADW{1'b0}}, mask_vec};
                SEL_EN_SET:   rd_q <= {{PADW{1'b0}}, en_vec};
                default:      rd_q <= '0;
            endcase
        end else begin
            rd_q <= '0;
        end
    end

    assign bus_rd_data = rd_q;
    assign chan_en     = en_vec;

    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_data[DW-1:NCH] == '0);

    // R11
    idle_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> (bus_rd_data == '0));

    // R7
    clr_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && (sel == SEL_MASK_CLR || sel == SEL_EN_CLR)) |=> (bus_rd_data == '0));

    // R8
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && sel == SEL_NONE) |=> ($stable(mask_vec) && $stable(en_vec)));

endmodule

// File: tb/tb_dma_chctl_regs.sv
module tb_dma_chctl_regs;

    localparam int NCH = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic            bus_wr_en = 1'b0;
    logic [31:0]     bus_wr_data = '0;
    logic            bus_rd_en = 1'b0;
    logic [31:0]     bus_rd_data;
    logic [NCH-1:0]  periph_req = '0;
    logic [NCH-1:0]  gated_req;
    logic [NCH-1:0]  chan_en;

    int checks = 0;
    int fails  = 0;
    logic [NCH-1:0] m_mask = '0;
    logic [NCH-1:0] m_en   = '0;

    always #4 clk = ~clk;

    dma_chctl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .periph_req(periph_req), .gated_req(gated_req), .chan_en(chan_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wr_data = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 chan_en", 32'(chan_en), 32'h0);
        check("R1 gated_req", 32'(gated_req), 32'h0);
        check("R1 rd_data", bus_rd_data, 32'h0);
        bus_read(8'h20, d); check("R1 mask", d, 32'h0);
        bus_read(8'h28, d); check("R1 enable", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        bus_write(8'h20, 32'h0000_0005); m_mask = 14'h0005;
        bus_read(8'h20, d); check("R2 set", d, 32'(m_mask));
        bus_write(8'h20, 32'h0000_2000); m_mask = 14'h2005;
        bus_read(8'h20, d); check("R2 zeros keep", d, 32'(m_mask));
        bus_write(8'h20, 32'hFFFF_C000);
        bus_read(8'h20, d); check("R2 upper ignored", d, 32'(m_mask));
        bus_write(8'h24, 32'h0000_0001); m_mask = 14'h2004;
        bus_read(8'h20, d); check("R3 clear", d, 32'(m_mask));
        bus_write(8'h24, 32'h0000_0000);
        bus_read(8'h20, d); check("R3 zeros keep", d, 32'(m_mask));
        bus_read(8'h24, d); check("R7 mask-clr read", d, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_write(8'h28, 32'h0000_3FFF); m_en = 14'h3FFF;
        check("R10 chan_en after set", 32'(chan_en), 32'(m_en));
        bus_read(8'h28, d); check("R4 R6 enable read", d, 32'(m_en));
        bus_write(8'h2C, 32'h0000_00F0); m_en = 14'h3F0F;
        check("R10 chan_en after clr", 32'(chan_en), 32'(m_en));
        bus_read(8'h28, d); check("R5 enable clear", d, 32'(m_en));
        bus_read(8'h2C, d); check("R7 en-clr read", d, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        logic [7:0] addrs [4] = '{8'h00, 8'h30, 8'h21, 8'hFC};
        for (int i = 0; i < 4; i++) begin
            bus_write(addrs[i], 32'hFFFF_FFFF);
            bus_read(addrs[i], d); check("R8 unmapped read", d, 32'h0);
        end
        bus_read(8'h20, d); check("R8 mask untouched", d, 32'(m_mask));
        bus_read(8'h28, d); check("R8 enable untouched", d, 32'(m_en));
    endtask

    task automatic t_gate();
        logic [NCH-1:0] pats [3] = '{14'h3FFF, 14'h2AAA, 14'h1555};
        logic [NCH-1:0] prev;
        prev = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            periph_req = pats[i];
            check("R9 latency", 32'(gated_req), 32'(prev & ~m_mask & m_en));
            @(negedge clk);
            check("R9 gated", 32'(gated_req), 32'(pats[i] & ~m_mask & m_en));
            prev = pats[i];
        end
        bus_write(8'h24, 32'h0000_3FFF); m_mask = '0;
        @(negedge clk);
        check("R9 unmasked", 32'(gated_req), 32'(prev & m_en));
        periph_req = '0;
        @(negedge clk);
    endtask

    task automatic t_idle_rd();
        logic [31:0] d;
        bus_read(8'h28, d); check("R6 read", d, 32'(m_en));
        @(negedge clk);
        check("R11 idle zero", bus_rd_data, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_enable();
        t_unmapped();
        t_gate();
        t_idle_rd();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule